// File: doc/BRIEF.md
# Serial-Loaded Double-Buffered DAC Front End

This block is the digital control side of a current-output converter that is loaded over a three-wire serial link. A host lowers an active-low frame strobe, clocks sixteen bits into the device most significant bit first, then raises the strobe. The two leading bits of the frame select an action: load a new converter code, return the present code on the serial output, or choose which serial clock edge captures data. The code sits left-justified in the remaining fourteen bits, and its width (12 or 14) is a parameter.

The serial pins are sampled by a system clock at least four times faster than the serial clock. Each pin passes through a two-flop synchronizer, and edges are found from the synchronized samples. A frame runs a command only when exactly sixteen capture edges arrived between strobe fall and strobe rise. A loaded code passes through an input latch into the converter register, so the converter input changes only in one clean step. The serial output shifts out the previous frame on the edge opposite the capture edge, so several devices can be chained. After a readback command it shifts out the converter code instead.

Top module: `sdac_frontend`

## Requirements
- R1: After reset the converter code output is 0, the serial output is 0 and the capture edge is the falling serial clock edge.
- R2: A frame with control bits [15:14] = 00 loads frame bits [13:14-CODE_W] (most significant first) into the converter code output, a few system cycles after the strobe rises.
- R3: With CODE_W = 12, frame bits [1:0] of a load frame have no effect on the converter code.
- R4: A frame with fewer or more than 16 capture edges runs no command: the converter code, the capture edge and the readback state stay unchanged.
- R5: Control bits 10 switch capture to the rising serial clock edge, and later frames are captured on rising edges.
- R6: Control bits 11 switch capture back to the falling serial clock edge.
- R7: During a frame the serial output presents the previous frame's 16 bits, most significant first. The first bit is valid before the first capture edge, and each later bit is updated on the edge opposite the capture edge.
- R8: Control bits 01 leave the converter code unchanged. The following frame shifts out, on the serial output, the word with bits [15:14] = 00, the code in bits [13:14-CODE_W] and zeros below.
- R9: While the strobe is high, serial clock and data activity has no effect: the serial output holds its last value and the converter code is unchanged.
- R10: The converter code output changes only as the second step of a load, one system cycle after the input latch is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_pin | input | 1 | Serial clock from the host |
| fsync_n_pin | input | 1 | Active-low frame strobe |
| sdi_pin | input | 1 | Serial data in |
| sdo_pin | output | 1 | Serial data out, for chaining and readback |
| dac_code | output | CODE_W | Converter register driving the analog ladder |

## Verification
The hardest cases to reach are a capture on the wrong clock edge and a wrong frame length, because a correct-looking frame hides both. The bench changes the data line to its complement between each capture edge and the following opposite edge. A design that samples on the wrong edge then loads the complement of the code. Frames of 15 and 17 edges are sent on purpose and must leave the code untouched. Readback needs two frames: a command frame, then a harmless edge-select frame whose serial output is collected bit by bit.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int FRAME_W = 16;
   typedef enum logic [1:0] {
      CMD_LOAD = 2'b00,
      CMD_READ = 2'b01,
      CMD_RISE = 2'b10,
      CMD_FALL = 2'b11
   } cmd_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int N = 3,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_in,
   output logic [N-1:0] q_out
);
   if (N < 1) begin : g_bad_n
      $error("sdac_sync: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic st1, st2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st1 <= RST_VAL[i];
            st2 <= RST_VAL[i];
         end else begin
            st1 <= d_in[i];
            st2 <= st1;
         end
      end
      assign q_out[i] = st2;
   end
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic fsync_n_s,
   input  logic rise_mode,
   output logic cap_edge,
   output logic out_edge,
   output logic frm_start,
   output logic frm_end
);
   logic sclk_d, fsync_d;
   logic sclk_up, sclk_dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         fsync_d <= 1'b1;
      end else begin
         sclk_d  <= sclk_s;
         fsync_d <= fsync_n_s;
      end
   end

   assign sclk_up   = sclk_s & ~sclk_d;
   assign sclk_dn   = ~sclk_s & sclk_d;
   assign cap_edge  = rise_mode ? sclk_up : sclk_dn;
   assign out_edge  = rise_mode ? sclk_dn : sclk_up;
   assign frm_start = fsync_d & ~fsync_n_s;
   assign frm_end   = ~fsync_d & fsync_n_s;

   assert_edges_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_edge && out_edge));
   assert_frame_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(frm_start && frm_end));
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
   parameter int FRAME_W = 16,
   parameter int CODE_W  = 12,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               din_s,
   input  logic               cap_edge,
   input  logic               out_edge,
   input  logic               frm_start,
   input  logic               frm_end,
   input  logic               rb_load,
   input  logic [CODE_W-1:0]  rb_code,
   output logic [FRAME_W-1:0] word,
   output logic [CNT_W-1:0]   edge_cnt,
   output logic               sdo
);
   localparam int                CNT_MAX = FRAME_W + 1;
   localparam logic [CNT_W-1:0]  CNT_TOP = CNT_W'(CNT_MAX);

   logic               in_frame;
   logic [FRAME_W-1:0] rb_word;

   always_comb begin
      rb_word = '0;
      rb_word[FRAME_W-3 -: CODE_W] = rb_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         word     <= '0;
         edge_cnt <= '0;
         sdo      <= 1'b0;
      end else if (frm_start) begin
         in_frame <= 1'b1;
         edge_cnt <= '0;
         sdo      <= word[FRAME_W-1];
      end else begin
         if (frm_end) in_frame <= 1'b0;
         if (in_frame && cap_edge) begin
            word <= {word[FRAME_W-2:0], din_s};
            if (edge_cnt != CNT_TOP) edge_cnt <= edge_cnt + 1'b1;
         end
         if (in_frame && out_edge) sdo <= word[FRAME_W-1];
         if (rb_load) word <= rb_word;
      end
   end

   assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_cnt <= CNT_TOP);
   assert_sdo_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame && !frm_start) |=> $stable(sdo));
   assert_sdo_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!frm_start && !out_edge) |=> $stable(sdo));
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
   import sdac_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int CODE_W  = 12,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_end,
   input  logic [CNT_W-1:0]   edge_cnt,
   input  logic [FRAME_W-1:0] word,
   output logic               rise_mode,
   output logic               rb_load,
   output logic [CODE_W-1:0]  dac_q
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic              exec;
   cmd_e              cmd;
   logic [CODE_W-1:0] latch_q;
   logic              xfer_q;

   assign exec = frm_end && (edge_cnt == CNT_FULL);
   assign cmd  = cmd_e'(word[FRAME_W-1 -: 2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_mode <= 1'b0;
         rb_load   <= 1'b0;
         latch_q   <= '0;
         xfer_q    <= 1'b0;
         dac_q     <= '0;
      end else begin
         rb_load <= 1'b0;
         xfer_q  <= 1'b0;
         if (exec) begin
            unique case (cmd)
               CMD_LOAD: begin
                  latch_q <= word[FRAME_W-3 -: CODE_W];
                  xfer_q  <= 1'b1;
               end
               CMD_READ: rb_load   <= 1'b1;
               CMD_RISE: rise_mode <= 1'b1;
               CMD_FALL: rise_mode <= 1'b0;
               default:  ;
            endcase
         end
         if (xfer_q) dac_q <= latch_q;
      end
   end

   assert_dac_only_on_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_q |=> $stable(dac_q));
   assert_mode_only_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_end |=> $stable(rise_mode));
   assert_read_keeps_dac_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rb_load |-> !xfer_q);
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
   import sdac_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_pin,
   input  logic              fsync_n_pin,
   input  logic              sdi_pin,
   output logic              sdo_pin,
   output logic [CODE_W-1:0] dac_code
);
   localparam int CNT_W = $clog2(FRAME_W + 2);

   if (!(CODE_W == 12 || CODE_W == 14)) begin : g_bad_width
      $error("sdac_frontend: CODE_W must be 12 or 14");
   end

   logic [2:0]         pins_s;
   logic               sclk_s, fsync_n_s, din_s;
   logic               rise_mode, cap_edge, out_edge, frm_start, frm_end;
   logic               rb_load;
   logic [FRAME_W-1:0] word;
   logic [CNT_W-1:0]   edge_cnt;

   sdac_sync #(.N(3), .RST_VAL(3'b010)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .d_in({sdi_pin, fsync_n_pin, sclk_pin}),
      .q_out(pins_s));

   assign sclk_s    = pins_s[0];
   assign fsync_n_s = pins_s[1];
   assign din_s     = pins_s[2];

   sdac_edge edge_i (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .fsync_n_s(fsync_n_s),
      .rise_mode(rise_mode), .cap_edge(cap_edge), .out_edge(out_edge),
      .frm_start(frm_start), .frm_end(frm_end));

   sdac_shift #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .din_s(din_s), .cap_edge(cap_edge),
      .out_edge(out_edge), .frm_start(frm_start), .frm_end(frm_end),
      .rb_load(rb_load), .rb_code(dac_code), .word(word),
      .edge_cnt(edge_cnt), .sdo(sdo_pin));

   sdac_ctrl #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .edge_cnt(edge_cnt),
      .word(word), .rise_mode(rise_mode), .rb_load(rb_load), .dac_q(dac_code));
endmodule

// File: tb/sdac_frontend_tb.sv
module sdac_frontend_tb_top;
   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sclk = 1'b1;
   logic          fsync_n = 1'b1;
   logic          sdi = 1'b0;
   logic          sdo;
   logic [CW-1:0] code;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  rise_m = 1'b0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   sdac_frontend #(.CODE_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .fsync_n_pin(fsync_n),
      .sdi_pin(sdi), .sdo_pin(sdo), .dac_code(code));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input logic [1:0] c, input logic [CW-1:0] v,
                                      input logic [1:0] lsb);
      return {c, v, lsb};
   endfunction

   // One frame; captured data sits on the active edge, complement near the other edge.
   task automatic frame(input logic [15:0] w, input int nedges, output logic [15:0] got);
      logic idle;
      idle = rise_m ? 1'b0 : 1'b1;
      got = '0;
      sclk = idle;
      sdi = 1'b0;
      tick(4);
      fsync_n = 1'b0;
      tick(4);
      for (int i = 0; i < nedges; i++) begin
         logic b;
         b = (i < 16) ? w[15-i] : 1'b0;
         sdi = b;
         tick(4);
         if (i < 16) got = {got[14:0], sdo};
         sclk = ~idle;
         tick(2);
         sdi = ~b;
         tick(2);
         sclk = idle;
      end
      tick(4);
      fsync_n = 1'b1;
      tick(12);
   endtask

   task automatic t_reset();
      chk("R1 code after reset", int'(code), 0);
      chk("R1 sdo after reset", int'(sdo), 0);
   endtask

   task automatic t_load();
      logic [15:0] g;
      frame(mk(2'b00, 12'hA5C, 2'b11), 16, g);
      chk("R2 load A5C", int'(code), 'hA5C);
      chk("R1 default falling capture", int'(code), 'hA5C);
      frame(mk(2'b00, 12'h3F1, 2'b01), 16, g);
      chk("R3 low bits ignored", int'(code), 'h3F1);
      frame(mk(2'b00, 12'h3F1, 2'b10), 16, g);
      chk("R3 low bits ignored again", int'(code), 'h3F1);
   endtask

   task automatic t_bad_count();
      logic [15:0] g;
      frame(mk(2'b00, 12'h111, 2'b00), 15, g);
      chk("R4 15 edges discarded", int'(code), 'h3F1);
      frame(mk(2'b00, 12'h222, 2'b00), 17, g);
      chk("R4 17 edges discarded", int'(code), 'h3F1);
      frame(mk(2'b10, 12'h000, 2'b00), 15, g);
      frame(mk(2'b00, 12'h5A5, 2'b00), 16, g);
      chk("R4 short mode frame kept falling capture", int'(code), 'h5A5);
   endtask

   task automatic t_daisy();
      logic [15:0] g;
      frame(mk(2'b00, 12'h9C3, 2'b10), 16, g);
      frame(mk(2'b00, 12'h46E, 2'b01), 16, g);
      chk("R7 chained output is previous frame", int'(g), int'(mk(2'b00, 12'h9C3, 2'b10)));
      chk("R2 second load", int'(code), 'h46E);
   endtask

   task automatic t_readback();
      logic [15:0] g;
      frame(mk(2'b01, 12'hFFF, 2'b11), 16, g);
      chk("R8 readback keeps code", int'(code), 'h46E);
      frame(mk(2'b11, 12'h000, 2'b00), 16, g);
      chk("R8 readback word on sdo", int'(g), int'(mk(2'b00, 12'h46E, 2'b00)));
   endtask

   task automatic t_rising();
      logic [15:0] g;
      frame(mk(2'b10, 12'h000, 2'b00), 16, g);
      rise_m = 1'b1;
      frame(mk(2'b00, 12'hC35, 2'b00), 16, g);
      chk("R5 rising capture load", int'(code), 'hC35);
      frame(mk(2'b00, 12'h0AB, 2'b00), 16, g);
      chk("R7 chained output in rising mode", int'(g), int'(mk(2'b00, 12'hC35, 2'b00)));
      chk("R5 second rising load", int'(code), 'h0AB);
      frame(mk(2'b11, 12'h000, 2'b00), 16, g);
      rise_m = 1'b0;
      frame(mk(2'b00, 12'h7E2, 2'b00), 16, g);
      chk("R6 back to falling capture", int'(code), 'h7E2);
   endtask

   task automatic t_idle();
      logic s0;
      s0 = sdo;
      for (int i = 0; i < 8; i++) begin
         sdi = i[0];
         sclk = ~sclk;
         tick(4);
         if (sdo !== s0) begin
            chk("R9 sdo held while idle", int'(sdo), int'(s0));
         end
      end
      chk("R9 sdo held while idle", int'(sdo), int'(s0));
      chk("R9 code unchanged while idle", int'(code), 'h7E2);
      chk("R10 code stable after activity", int'(code), 'h7E2);
   endtask

   initial begin
      tick(5);
      t_reset();
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_load();
      t_bad_count();
      t_daisy();
      t_readback();
      t_rising();
      t_idle();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule